// File: doc/BRIEF.md
# SMBus Host Register Interface

This block is the register side of an SMBus host controller. Software uses a byte-wide port to program a target address, a command byte, two data bytes and a protocol selection. Setting the start bit in the control register turns these values into one request for a separate bus engine. The engine does the actual wire signalling. When it finishes, it answers on a response channel, and the block loads any read result into the data registers according to the selected protocol.

A 32-entry block buffer holds the payload for block transfers. Software reaches it through one data port whose index steps forward on every access and wraps from 31 back to 0. The engine reaches it directly by address. It reads the buffer for block writes and fills it for block reads. Software reads the control register to rewind the index to 0 before it walks the buffer.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, every register reads 0, the buffer index is 0 and `req_valid` is low.
- R2: Register offsets: status 0, control 2, command 3, address 4, data0 5, data1 6, block port 7. A read of control returns bits 4:0 of the last control write, with bits 7:5 always read as 0. Any read of control also sets the buffer index to 0.
- R3: A control write with bit 6 set, issued while not busy and with a legal protocol code in control bits 4:2, raises `req_valid` and sets status bit 0 (busy). The request carries:
  - `req_target` taken from address bits 7:1;
  - `req_read` taken from address bit 0, where 1 means read;
  - `req_proto`, `req_cmd`, `req_data` = {data1, data0} and `req_count` = data0 bits 5:0.
  Bit 6 is not stored.
- R4: Protocol codes 4, 6 and 7 are illegal. A start with one of them sets status bit 2 (failed) and issues no request. The legal codes are 0 quick, 1 byte, 2 byte-data, 3 word-data and 5 block.
- R5: `req_valid` and every request field stay unchanged until the cycle in which `req_ready` is high.
- R6: A response pulse (`rsp_valid`) that arrives while busy, after the request has been taken, clears busy and sets status bit 1 (done). Writing 1 to status bits 0, 1 or 2 clears that bit.
- R7: A byte or byte-data read loads `rsp_data[7:0]` into data0 and leaves data1 unchanged.
- R8: A word read loads `rsp_data[7:0]` into data0 and `rsp_data[15:8]` into data1.
- R9: A block read loads the byte count from `rsp_data[7:0]` into data0. A block write presents data0 bits 5:0 as `req_count`.
- R10: Every read or write of the block port accesses the entry at the current index and then moves the index forward by one. The index wraps from 31 to 0.
- R11: A start written while busy is ignored, and the pending request is left unchanged.
- R12: A write-direction response, or a quick read response, leaves data0 and data1 unchanged.
- R13: The engine reads any buffer entry through `eng_buf_addr`/`eng_buf_rdata`. A write with `eng_buf_we` stores `eng_buf_wdata` at that address, and the host port can then read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Transaction request pending |
| req_ready | input | 1 | Engine takes the request |
| req_proto | output | 3 | Protocol code |
| req_read | output | 1 | 1 for a read transfer |
| req_target | output | 7 | 7-bit target address |
| req_cmd | output | 8 | Command byte |
| req_data | output | 16 | {data1, data0} for writes |
| req_count | output | 6 | Block write byte count |
| rsp_valid | input | 1 | Transaction finished |
| rsp_data | input | 16 | Read result or block count |
| eng_buf_addr | input | 5 | Engine buffer address |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Engine buffer read data |

## Verification
The embedded properties check the following on every cycle:
- the request stays stable while it waits for `req_ready`;
- an illegal protocol code raises the failed flag;
- a response sets done;
- the buffer index steps by one on each block-port access and rewinds on a control read;
- a start made while busy leaves the pending request untouched.

Only the bench scenarios can show the rest. These are which byte of the response lands in which data register for each protocol and direction, that the data registers are left untouched after write or quick transfers, and that the wrapped index overwrites the first entries. The handover of buffer contents between the host port and the engine port also needs a scenario.

// File: rtl/smbus_host_regs.sv
module smbus_host_regs #(
  parameter int BUF_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [2:0]  req_proto,
  output logic        req_read,
  output logic [6:0]  req_target,
  output logic [7:0]  req_cmd,
  output logic [15:0] req_data,
  output logic [5:0]  req_count,
  input  logic        rsp_valid,
  input  logic [15:0] rsp_data,
  input  logic [4:0]  eng_buf_addr,
  input  logic        eng_buf_we,
  input  logic [7:0]  eng_buf_wdata,
  output logic [7:0]  eng_buf_rdata
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [2:0] A_STS = 3'd0, A_CTL = 3'd2, A_CMD = 3'd3, A_ADR = 3'd4,
                         A_D0 = 3'd5, A_D1 = 3'd6, A_BLK = 3'd7;
  localparam logic [2:0] P_QUICK = 3'd0, P_BYTE = 3'd1, P_BDATA = 3'd2,
                         P_WORD = 3'd3, P_BLOCK = 3'd5;

  logic [4:0]       ctl;
  logic [7:0]       cmd, adr, d0, d1;
  logic             st_busy, st_done, st_fail;
  logic [IDX_W-1:0] idx;
  logic [7:0]       buf_mem [BUF_DEPTH];

  wire blk_acc   = (reg_wr || reg_rd) && reg_addr == A_BLK;
  wire start_wr  = reg_wr && reg_addr == A_CTL && reg_wdata[6];
  wire [2:0] new_proto = reg_wdata[4:2];
  wire proto_ok  = new_proto inside {P_QUICK, P_BYTE, P_BDATA, P_WORD, P_BLOCK};
  wire rsp_take  = rsp_valid && st_busy && !req_valid;

  assign eng_buf_rdata = buf_mem[eng_buf_addr[IDX_W-1:0]];

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {5'd0, st_fail, st_done, st_busy};
      A_CTL:   reg_rdata = {3'd0, ctl};
      A_CMD:   reg_rdata = cmd;
      A_ADR:   reg_rdata = adr;
      A_D0:    reg_rdata = d0;
      A_D1:    reg_rdata = d1;
      A_BLK:   reg_rdata = buf_mem[idx];
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (eng_buf_we) buf_mem[eng_buf_addr[IDX_W-1:0]] <= eng_buf_wdata;
    if (reg_wr && reg_addr == A_BLK) buf_mem[idx] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; cmd <= '0; adr <= '0; d0 <= '0; d1 <= '0; idx <= '0;
      st_busy <= 1'b0; st_done <= 1'b0; st_fail <= 1'b0;
      req_valid <= 1'b0; req_proto <= '0; req_read <= 1'b0; req_target <= '0;
      req_cmd <= '0; req_data <= '0; req_count <= '0;
    end else begin
      if (blk_acc) idx <= idx + 1'b1;
      else if (reg_rd && reg_addr == A_CTL) idx <= '0;
      if (reg_wr) begin
        case (reg_addr)
          A_STS: begin
            if (reg_wdata[0]) st_busy <= 1'b0;
            if (reg_wdata[1]) st_done <= 1'b0;
            if (reg_wdata[2]) st_fail <= 1'b0;
          end
          A_CTL:   ctl <= reg_wdata[4:0];
          A_CMD:   cmd <= reg_wdata;
          A_ADR:   adr <= reg_wdata;
          A_D0:    d0  <= reg_wdata;
          A_D1:    d1  <= reg_wdata;
          default: ;
        endcase
      end
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (start_wr && !st_busy) begin
        if (proto_ok) begin
          st_busy    <= 1'b1;
          req_valid  <= 1'b1;
          req_proto  <= new_proto;
          req_read   <= adr[0];
          req_target <= adr[7:1];
          req_cmd    <= cmd;
          req_data   <= {d1, d0};
          req_count  <= d0[5:0];
        end else begin
          st_fail <= 1'b1;
        end
      end
      if (rsp_take) begin
        st_busy <= 1'b0;
        st_done <= 1'b1;
        if (req_read) begin
          case (req_proto)
            P_BYTE, P_BDATA, P_BLOCK: d0 <= rsp_data[7:0];
            P_WORD: begin d0 <= rsp_data[7:0]; d1 <= rsp_data[15:8]; end
            default: ;
          endcase
        end
      end
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_target) && $stable(req_proto)
      && $stable(req_cmd) && $stable(req_data) && $stable(req_read));

  p_bad_proto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !st_busy && !proto_ok |=> st_fail);

  p_rsp_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> st_done);

  p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_acc |=> idx == $past(idx) + 1'b1);

  p_ctl_rd_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_CTL |=> idx == '0);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && st_busy |=> $stable(req_target) && $stable(req_proto) && $stable(req_cmd));
endmodule

// File: tb/smbus_host_regs_bench.sv
module smbus_host_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, req_ready = 0, rsp_valid = 0, eng_buf_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, eng_buf_wdata = 0;
  logic [15:0] rsp_data = 0;
  logic [4:0] eng_buf_addr = 0;
  logic [7:0] reg_rdata, eng_buf_rdata, rv;
  logic req_valid, req_read;
  logic [2:0] req_proto;
  logic [6:0] req_target;
  logic [7:0] req_cmd;
  logic [15:0] req_data;
  logic [5:0] req_count;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  smbus_host_regs u_smbus_host_regs (.*);

  // proto, addr, cmd, d0, d1, rsp[15:0], exp_d0, exp_d1
  localparam logic [71:0] VEC [0:8] = '{
    {8'd0, 8'h50, 8'h11, 8'h01, 8'h02, 16'hFFFF, 8'h01, 8'h02},
    {8'd1, 8'hA1, 8'h00, 8'h00, 8'h33, 16'h1234, 8'h34, 8'h33},
    {8'd1, 8'hA0, 8'h5A, 8'h77, 8'h66, 16'hABCD, 8'h77, 8'h66},
    {8'd2, 8'h31, 8'h09, 8'h00, 8'h44, 16'h00C3, 8'hC3, 8'h44},
    {8'd3, 8'h91, 8'h0C, 8'h00, 8'h00, 16'hBEEF, 8'hEF, 8'hBE},
    {8'd3, 8'h90, 8'h0D, 8'h12, 8'h34, 16'h0000, 8'h12, 8'h34},
    {8'd5, 8'h17, 8'h20, 8'h00, 8'h55, 16'h0009, 8'h09, 8'h55},
    {8'd5, 8'h16, 8'h21, 8'h20, 8'h00, 16'h00FF, 8'h20, 8'h00},
    {8'd0, 8'h51, 8'h22, 8'h0A, 8'h0B, 16'hAAAA, 8'h0A, 8'h0B}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic finish_txn(input logic [15:0] r);
    @(negedge clk); req_ready = 1;
    @(negedge clk); req_ready = 0; rsp_data = r; rsp_valid = 1;
    @(negedge clk); rsp_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, rv); chk("R1 status", rv, 0);
    rd(3'd2, rv); chk("R1 control", rv, 0);
    rd(3'd5, rv); chk("R1 data0", rv, 0);
    chk("R1 req_valid", req_valid, 0);

    wr(3'd2, 8'hBF); rd(3'd2, rv); chk("R2 control mask", rv, 8'h1F);
    chk("R2 no start without bit6", req_valid, 0);

    for (int i = 0; i < 9; i++) begin
      wr(3'd5, VEC[i][47:40]); wr(3'd6, VEC[i][39:32]);
      wr(3'd3, VEC[i][55:48]); wr(3'd4, VEC[i][63:56]);
      wr(3'd2, {1'b0, 1'b1, 1'b0, VEC[i][66:64], 2'b00});
      @(negedge clk);
      chk("R3 req_valid", req_valid, 1);
      chk("R3 target", req_target, VEC[i][63:57]);
      chk("R3 read", req_read, VEC[i][56]);
      chk("R3 proto", req_proto, VEC[i][66:64]);
      chk("R3 cmd", req_cmd, VEC[i][55:48]);
      chk("R8 req_data", req_data, {VEC[i][39:32], VEC[i][47:40]});
      chk("R9 req_count", req_count, VEC[i][45:40]);
      rd(3'd0, rv); chk("R3 busy", rv, 8'h01);
      rd(3'd2, rv); chk("R3 start not stored", rv, {3'b0, VEC[i][66:64], 2'b00});
      chk("R5 still pending", req_valid, 1);
      finish_txn(VEC[i][31:16]);
      chk("R5 taken", req_valid, 0);
      rd(3'd0, rv); chk("R6 done", rv, 8'h02);
      rd(3'd5, rv); chk("R7 R8 R9 R12 data0", rv, VEC[i][15:8]);
      rd(3'd6, rv); chk("R8 R12 data1", rv, VEC[i][7:0]);
      wr(3'd0, 8'h02); rd(3'd0, rv); chk("R6 w1c done", rv, 0);
    end

    // illegal protocols
    wr(3'd2, 8'h5C); @(negedge clk);
    chk("R4 no request code7", req_valid, 0);
    rd(3'd0, rv); chk("R4 failed", rv, 8'h04);
    wr(3'd0, 8'h04); rd(3'd0, rv); chk("R6 w1c failed", rv, 0);
    wr(3'd2, 8'h50); @(negedge clk);
    chk("R4 no request code4", req_valid, 0);
    rd(3'd0, rv); chk("R4 failed code4", rv, 8'h04);
    wr(3'd0, 8'h04);

    // start while busy
    wr(3'd4, 8'h40); wr(3'd3, 8'h01); wr(3'd2, 8'h48);
    wr(3'd4, 8'h62); wr(3'd3, 8'h02); wr(3'd2, 8'h44);
    chk("R11 target kept", req_target, 7'h20);
    chk("R11 cmd kept", req_cmd, 8'h01);
    chk("R11 proto kept", req_proto, 3'd2);
    finish_txn(16'h0000);
    wr(3'd0, 8'h02);

    // block buffer with wrap
    rd(3'd2, rv);
    for (int i = 0; i < 34; i++) wr(3'd7, 8'(i + 16));
    #1 eng_buf_addr = 5'd5;
    #1 chk("R13 engine read", eng_buf_rdata, 8'h15);
    @(negedge clk); eng_buf_addr = 5'd3; eng_buf_wdata = 8'hA5; eng_buf_we = 1;
    @(negedge clk); eng_buf_we = 0;
    rd(3'd2, rv);
    for (int i = 0; i < 33; i++) begin
      rd(3'd7, rv);
      if (i == 0) chk("R10 wrap entry0", rv, 8'h30);
      else if (i == 1) chk("R10 wrap entry1", rv, 8'h31);
      else if (i == 3) chk("R13 engine write", rv, 8'hA5);
      else if (i == 32) chk("R10 index wrapped", rv, 8'h30);
      else if (i == 31) chk("R10 entry31", rv, 8'h2F);
    end
    rd(3'd2, rv); rd(3'd7, rv); chk("R2 control read rewinds", rv, 8'h30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule